// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a column command into the run of column addresses that an SDRAM burst visits. A mode-set strobe captures the burst length, the wrap order, the CAS latency and a write-single option from the address bus. After that, each read or write strobe arrives with a starting column and launches a burst. For the length of the burst, the block emits one column per clock, together with a valid flag, a last-beat flag and a flag that marks the burst as a write.

The sequential wrap order counts upward inside the aligned block of burst-length columns and wraps around within that block. The interleaved order combines the starting offset with the beat number by XOR. In both orders the column bits above the block stay fixed. A new column command may arrive on any clock, and it cuts off the burst in progress at once. The array access and the data path are left to the surrounding logic. That logic reads the programmed latency from `cas_lat_o`.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `col_valid_o`, `col_last_o`, `col_write_o` and `col_o` are 0. The mode is burst length 1, sequential order, latency 2 and write-single off.
- R2: A mode-set cycle loads the burst length from addr_i[2:0]: 000=1, 001=2, 010=4, 011=8.
- R3: A mode-set cycle loads the wrap order from addr_i[3], where 0 is sequential and 1 is interleaved. It loads the write-single option from addr_i[9], where 1 is on.
- R4: A mode-set cycle loads the CAS latency from addr_i[6:4]: 010=2, 011=3. `cas_lat_o` shows the latency from the next clock onward. Any other latency code leaves the latency unchanged.
- R5: A mode-set cycle with addr_i[2] = 1 leaves the burst length unchanged. The other fields still load.
- R6: A column command sampled at a clock edge produces beat 0 after that edge. The following beats come one per clock, with `col_valid_o` high for exactly burst-length cycles. A command uses the mode that is in force before a mode-set in the same cycle.
- R7: In sequential order, beat k has low bits (start + k) mod BL within the aligned block.
- R8: In interleaved order, beat k has low bits start XOR k within the aligned block.
- R9: Column bits above the aligned block equal those of the starting column on every beat.
- R10: `col_last_o` is high only on the final beat of a burst. Without a new command, `col_valid_o` is low on the next clock.
- R11: A column command during a burst restarts the sequence from the new start on the next clock.
- R12: With write-single on, a write burst has exactly one beat. A read keeps the programmed length.
- R13: `col_write_o` is high during a burst launched by `wr_i`. When `wr_i` and `rd_i` are both high, the command is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_set_i | input | 1 | Load mode fields from addr_i |
| addr_i | input | 12 | Mode field bus |
| rd_i | input | 1 | Read column command |
| wr_i | input | 1 | Write column command |
| col_i | input | COL_W (11) | Starting column of the command |
| col_o | output | COL_W (11) | Column of the current beat, 0 when idle |
| col_valid_o | output | 1 | A beat is present |
| col_last_o | output | 1 | Final beat of the burst |
| col_write_o | output | 1 | Current burst is a write |
| cas_lat_o | output | 2 | Programmed CAS latency |

## Verification
The directed cases run every burst length in both wrap orders. They use starting columns that sit mid-block and near the top of the column space, so that a modulo error or a change to the upper bits shows in the column values. Separate cases cover reserved length and latency codes, preemption on each beat position, write-single for reads against writes, and a read and a write issued together. A seeded random phase then mixes mode changes, including reserved codes, with commands on arbitrary clocks. That phase checks every output on every cycle against a model in the bench, which finds faults in counter wrap, in how the length is chosen and in the order in which a mode change and a command take effect.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;
  localparam int unsigned MAX_BL = 8;
  localparam int unsigned BEAT_W = $clog2(MAX_BL);

  typedef enum logic {WRAP_SEQ = 1'b0, WRAP_XOR = 1'b1} wrap_e;

  typedef struct packed {
    logic [1:0] bl_log;
    wrap_e      wrap;
    logic [1:0] cas_lat;
    logic       wr_single;
  } mode_t;

  function automatic logic [BEAT_W-1:0] len_mask(input logic [1:0] bl_log);
    return BEAT_W'((4'd1 << bl_log) - 4'd1);
  endfunction
endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_colgen_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output mode_t             mode_o
);
  mode_t mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (!addr_i[2]) mode_d.bl_log = addr_i[1:0];
    mode_d.wrap      = wrap_e'(addr_i[3]);
    mode_d.wr_single = addr_i[9];
    if (addr_i[6:4] == 3'b010) mode_d.cas_lat = 2'd2;
    else if (addr_i[6:4] == 3'b011) mode_d.cas_lat = 2'd3;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q.bl_log    <= 2'd0;
      mode_q.wrap      <= WRAP_SEQ;
      mode_q.cas_lat   <= 2'd2;
      mode_q.wr_single <= 1'b0;
    end else if (load_i) begin
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_colgen_pkg::*;
#(
  parameter int unsigned COL_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [COL_W-1:0]  col_i,
  input  mode_t             mode_i,
  output logic              act_o,
  output logic              last_o,
  output logic              is_wr_o,
  output logic [BEAT_W-1:0] cnt_o,
  output logic [BEAT_W-1:0] mask_o,
  output wrap_e             wrap_o,
  output logic [COL_W-1:0]  start_o
);
  logic              act_q, act_d;
  logic [BEAT_W-1:0] cnt_q, cnt_d;
  logic [BEAT_W-1:0] mask_q, mask_d;
  wrap_e             wrap_q, wrap_d;
  logic              wr_q, wr_d;
  logic [COL_W-1:0]  start_q, start_d;
  logic              launch, at_last, step_en;

  assign launch  = rd_i | wr_i;
  assign at_last = act_q && (cnt_q == mask_q);
  assign step_en = launch | act_q;

  always_comb begin
    act_d   = act_q;
    cnt_d   = cnt_q;
    mask_d  = mask_q;
    wrap_d  = wrap_q;
    wr_d    = wr_q;
    start_d = start_q;
    if (launch) begin
      act_d   = 1'b1;
      cnt_d   = '0;
      start_d = col_i;
      wrap_d  = mode_i.wrap;
      wr_d    = wr_i;
      mask_d  = (wr_i && mode_i.wr_single) ? '0 : len_mask(mode_i.bl_log);
    end else if (at_last) begin
      act_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      cnt_q   <= '0;
      mask_q  <= '0;
      wrap_q  <= WRAP_SEQ;
      wr_q    <= 1'b0;
      start_q <= '0;
    end else if (step_en) begin
      act_q   <= act_d;
      cnt_q   <= cnt_d;
      mask_q  <= mask_d;
      wrap_q  <= wrap_d;
      wr_q    <= wr_d;
      start_q <= start_d;
    end
  end

  assign act_o   = act_q;
  assign last_o  = at_last;
  assign is_wr_o = act_q & wr_q;
  assign cnt_o   = cnt_q;
  assign mask_o  = mask_q;
  assign wrap_o  = wrap_q;
  assign start_o = start_q;
endmodule

// File: rtl/sdram_col_order.sv
module sdram_col_order
  import sdram_colgen_pkg::*;
#(
  parameter int unsigned COL_W = 11
) (
  input  logic [COL_W-1:0]  start_i,
  input  logic [BEAT_W-1:0] cnt_i,
  input  logic [BEAT_W-1:0] mask_i,
  input  wrap_e             wrap_i,
  output logic [COL_W-1:0]  col_o
);
  logic [BEAT_W-1:0] base_low;
  logic [BEAT_W-1:0] off;

  assign base_low = start_i[BEAT_W-1:0];

  always_comb begin
    if (wrap_i == WRAP_XOR) off = (base_low ^ cnt_i) & mask_i;
    else                    off = (base_low + cnt_i) & mask_i;
  end

  assign col_o = {start_i[COL_W-1:BEAT_W], (base_low & ~mask_i) | off};
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_colgen_pkg::*;
#(
  parameter int unsigned COL_W  = 11,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_set_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [COL_W-1:0]  col_o,
  output logic              col_valid_o,
  output logic              col_last_o,
  output logic              col_write_o,
  output logic [1:0]        cas_lat_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  mode_t             mode;
  logic              act, last, is_wr;
  logic [BEAT_W-1:0] cnt, mask;
  wrap_e             wrap;
  logic [COL_W-1:0]  start, col_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sdram_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
    .clk(clk), .rst_n(rst_int_n), .load_i(mode_set_i), .addr_i(addr_i), .mode_o(mode)
  );

  sdram_burst_seq #(.COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .rd_i(rd_i), .wr_i(wr_i), .col_i(col_i),
    .mode_i(mode), .act_o(act), .last_o(last), .is_wr_o(is_wr), .cnt_o(cnt),
    .mask_o(mask), .wrap_o(wrap), .start_o(start)
  );

  sdram_col_order #(.COL_W(COL_W)) u_order (
    .start_i(start), .cnt_i(cnt), .mask_i(mask), .wrap_i(wrap), .col_o(col_raw)
  );

  assign col_o       = act ? col_raw : '0;
  assign col_valid_o = act;
  assign col_last_o  = last;
  assign col_write_o = is_wr;
  assign cas_lat_o   = mode.cas_lat;
endmodule

// File: rtl/sdram_colgen_chk.sv
module sdram_colgen_chk #(
  parameter int unsigned COL_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_set_i,
  input logic             rd_i,
  input logic             wr_i,
  input logic [COL_W-1:0] col_o,
  input logic             col_valid_o,
  input logic             col_last_o,
  input logic             col_write_o,
  input logic [1:0]       cas_lat_o
);
  AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    col_last_o |-> col_valid_o); // R10
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last_o && !rd_i && !wr_i) |=> !col_valid_o); // R10
  AST_CMD_GIVES_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i || wr_i) |=> col_valid_o); // R6
  AST_BURST_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid_o && !col_last_o) |=> col_valid_o); // R6
  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid_o && !col_last_o && !rd_i && !wr_i) |=>
      (col_o[COL_W-1:3] == $past(col_o[COL_W-1:3]))); // R9
  AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    col_write_o |-> col_valid_o); // R13
  AST_WR_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> col_write_o); // R13
  AST_CAS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat_o == 2'd2) || (cas_lat_o == 2'd3)); // R4
  AST_CAS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_set_i |=> $stable(cas_lat_o)); // R4
endmodule

bind sdram_burst_colgen sdram_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_set_i(mode_set_i), .rd_i(rd_i), .wr_i(wr_i),
  .col_o(col_o), .col_valid_o(col_valid_o), .col_last_o(col_last_o),
  .col_write_o(col_write_o), .cas_lat_o(cas_lat_o)
);

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;
  localparam int COL_W = 11;
  localparam int ADDR_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_set_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [COL_W-1:0]  col_i = '0;
  logic [COL_W-1:0]  col_o;
  logic col_valid_o, col_last_o, col_write_o;
  logic [1:0] cas_lat_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model state
  int m_bl = 1, m_cl = 2;
  bit m_xor = 0, m_ws = 0;
  bit b_act = 0, b_wr = 0, b_xor = 0;
  int b_cnt = 0, b_len = 1;
  logic [COL_W-1:0] b_start = '0;

  always #10 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .mode_set_i(mode_set_i), .addr_i(addr_i),
    .rd_i(rd_i), .wr_i(wr_i), .col_i(col_i), .col_o(col_o),
    .col_valid_o(col_valid_o), .col_last_o(col_last_o),
    .col_write_o(col_write_o), .cas_lat_o(cas_lat_o)
  );

  function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] s, int k, int len, bit x);
    logic [2:0] m, o;
    m = 3'(len - 1);
    o = x ? ((s[2:0] ^ 3'(k)) & m) : ((s[2:0] + 3'(k)) & m);
    return {s[COL_W-1:3], (s[2:0] & ~m) | o};
  endfunction

  function automatic logic [ADDR_W-1:0] mode_word(int blc, bit x, int clc, bit ws);
    logic [ADDR_W-1:0] w;
    w = '0;
    w[2:0] = 3'(blc); w[3] = x; w[6:4] = 3'(clc); w[9] = ws;
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare all outputs with model
  task automatic compare_all();
    logic [COL_W-1:0] ec;
    ec = b_act ? exp_col(b_start, b_cnt, b_len, b_xor) : '0;
    chk("R6 valid", 32'(col_valid_o), 32'(b_act));
    chk("R10 last", 32'(col_last_o), 32'(b_act && (b_cnt == b_len - 1)));
    chk(b_xor ? "R8/R9 interleaved col" : "R7/R9 sequential col", 32'(col_o), 32'(ec));
    chk("R13 write flag", 32'(col_write_o), 32'(b_act && b_wr));
    chk("R4 cas latency", 32'(cas_lat_o), 32'(m_cl));
  endtask

  // one cycle: check current state, drive inputs, advance model
  task automatic cycle(bit ms, logic [ADDR_W-1:0] a, bit rd, bit wr, logic [COL_W-1:0] c);
    @(negedge clk);
    compare_all();
    mode_set_i = ms; addr_i = a; rd_i = rd; wr_i = wr; col_i = c;
    if (rd || wr) begin
      b_act = 1; b_cnt = 0; b_start = c; b_xor = m_xor; b_wr = wr;
      b_len = (wr && m_ws) ? 1 : m_bl;
    end else if (b_act && b_cnt == b_len - 1) begin
      b_act = 0;
    end else if (b_act) begin
      b_cnt++;
    end
    if (ms) begin
      if (!a[2]) m_bl = 1 << a[1:0];
      m_xor = a[3]; m_ws = a[9];
      if (a[6:4] == 3'b010) m_cl = 2;
      else if (a[6:4] == 3'b011) m_cl = 3;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(0, '0, 0, 0, '0);
  endtask

  task automatic setmode(int blc, bit x, int clc, bit ws);
    cycle(1, mode_word(blc, x, clc, ws), 0, 0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1: reset state
    @(negedge clk);
    chk("R1 valid", 32'(col_valid_o), 0);
    chk("R1 col", 32'(col_o), 0);
    chk("R1 cas", 32'(cas_lat_o), 2);
    // R1: default burst length 1, sequential
    cycle(0, '0, 1, 0, 11'h2a5); idle(3);
    // R2 R7 R8 R9: all lengths both orders, upper bits near the top
    for (int x = 0; x < 2; x++)
      for (int blc = 0; blc < 4; blc++) begin
        setmode(blc, x[0], 3, 0);
        cycle(0, '0, 1, 0, 11'h7fd); idle(10);
        cycle(0, '0, 0, 1, 11'h13a); idle(10);
      end
    // R5: reserved length code keeps length 8; R4: reserved latency keeps 3
    setmode(3, 0, 3, 0);
    setmode(6, 1, 5, 0);
    cycle(0, '0, 1, 0, 11'h055); idle(10);
    setmode(1, 0, 2, 0); idle(2);
    // R6: mode-set together with command uses old mode (length 2)
    cycle(1, mode_word(3, 1, 3, 0), 1, 0, 11'h00f); idle(4);
    // R11: preemption at each beat position
    for (int p = 0; p < 8; p++) begin
      cycle(0, '0, 1, 0, 11'h101);
      idle(p);
      cycle(0, '0, 0, 1, 11'h7f6);
      idle(9);
    end
    // R12: write-single; writes single beat, reads full length
    setmode(3, 0, 2, 1);
    cycle(0, '0, 0, 1, 11'h333); idle(3);
    cycle(0, '0, 1, 0, 11'h333); idle(9);
    // R13: read and write together -> write
    cycle(0, '0, 1, 1, 11'h444); idle(3);
    setmode(2, 1, 3, 0);
    cycle(0, '0, 1, 1, 11'h446); idle(5);
    // R3 R2 R5 R11 R12: seeded random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit ms, rd, wr;
      r = $urandom_range(0, 99);
      ms = (r < 6);
      rd = (r >= 6 && r < 18);
      wr = (r >= 18 && r < 28) || (r == 29);
      if (r == 29) rd = 1;
      cycle(ms, ADDR_W'($urandom), rd, wr, COL_W'($urandom));
    end
    idle(10);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule